// File: doc/BRIEF.md
# Quadrature-Sampling Frequency Detector

This block finds the sign of the frequency error between a received NRZ data stream and a local oscillator during acquisition. At each rising data transition it captures an in-phase and a quadrature copy of the oscillator, reads the two bits as a Gray-coded quadrant, and compares that quadrant with the one captured at the previous transition. A step to the neighbouring quadrant in one direction produces a one-cycle "up" request for the loop. A step in the other direction produces a one-cycle "down" request. No step, or an ambiguous two-quadrant jump, produces nothing.

Once the captured quadrant stays put for a programmable run of consecutive transitions, the oscillator is taken as frequency-locked. The detector then falls silent, which leaves the phase detector in charge and keeps the loop from settling on a false frequency. The upstream logic delivers each data rising edge as a one-clock `edge_evt` pulse synchronous to `clk`. The lock state is presented as an active-low loss-of-lock output.

Top module: `qfd_freq_detector`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `up_o` and `dn_o` are 0 and `lol_n_o` is 0 (not locked).
- R2: The oscillator bits are only captured in a clock cycle where `edge_evt` is 1. Their values in other cycles have no effect on any output.
- R3: The quadrant position is defined as {I,Q}=00→0, 01→1, 11→2, 10→3. If an edge's position is one below the previous edge's position (modulo 4), `up_o` is 1 in the cycle after that edge.
- R4: If an edge's position is one above the previous edge's position (modulo 4), `dn_o` is 1 in the cycle after that edge.
- R5: An edge whose position differs from the previous one by two quadrants produces neither `up_o` nor `dn_o`.
- R6: The first edge after reset only stores a reference quadrant. It produces no pulse and does not count toward lock.
- R7: `up_o` and `dn_o` are never 1 together. Each is 1 only in the cycle directly after an edge event.
- R8: `lol_n_o` rises to 1 in the cycle after the LOCK_EDGES-th consecutive edge whose quadrant equals the previous one.
- R9: Any quadrant change at an edge (one step or a jump) drives `lol_n_o` to 0 in the next cycle and restarts the run count from zero.
- R10: While `lol_n_o` is 1, `up_o` and `dn_o` stay 0.
- R11: Cycles without an edge event neither advance nor clear the run count toward lock, and leave `lol_n_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| edge_evt | input | 1 | One-cycle marker of a rising data transition |
| osc_i | input | 1 | In-phase oscillator bit |
| osc_q | input | 1 | Quadrature oscillator bit |
| up_o | output | 1 | One-cycle request to raise oscillator frequency |
| dn_o | output | 1 | One-cycle request to lower oscillator frequency |
| lol_n_o | output | 1 | Loss-of-lock, low while not frequency-locked |

## Verification
The cycle-by-cycle properties are checked continuously:
- the up and down requests are mutually exclusive;
- a request only ever follows an edge event;
- each classified step turns into the matching request or into silence on the next cycle;
- any quadrant change drops lock at once;
- lock never moves on a cycle without an edge.

Other behaviour depends on history and can only be shown by the directed scenarios:
- the exact edge count at which lock is declared;
- that idle gaps do not disturb that count;
- that the first edge after reset is only a reference;
- that oscillator activity between edges is ignored.

// File: rtl/qfd_pkg.sv
package qfd_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_JUMP = 2'd2,
    STEP_BWD  = 2'd3
  } step_e;

  // Gray-coded {I,Q} to linear quadrant index: 00->0, 01->1, 11->2, 10->3
  function automatic logic [1:0] gray_to_pos(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction

  // Modulo-4 difference between the new and the stored quadrant
  function automatic step_e classify(input logic [1:0] now_pos,
                                     input logic [1:0] ref_pos);
    logic [1:0] diff;
    diff = now_pos - ref_pos;
    return step_e'(diff);
  endfunction

endpackage

// File: rtl/qfd_edge_sampler.sv
module qfd_edge_sampler
  import qfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  edge_evt,
  input  logic  osc_i,
  input  logic  osc_q,
  output logic  step_vld,
  output step_e step_kind
);

  logic [1:0] now_pos;
  logic [1:0] ref_pos;
  logic       ref_vld;

  assign now_pos   = gray_to_pos({osc_i, osc_q});
  assign step_kind = classify(now_pos, ref_pos);
  assign step_vld  = edge_evt & ref_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_pos <= 2'd0;
      ref_vld <= 1'b0;
    end else if (edge_evt) begin
      ref_pos <= now_pos;
      ref_vld <= 1'b1;
    end
  end

endmodule

// File: rtl/qfd_pulse_gen.sv
module qfd_pulse_gen
  import qfd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_vld,
  input  step_e step_kind,
  output logic  up_o,
  output logic  dn_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_o <= 1'b0;
      dn_o <= 1'b0;
    end else begin
      up_o <= step_vld && (step_kind == STEP_BWD);
      dn_o <= step_vld && (step_kind == STEP_FWD);
    end
  end

endmodule

// File: rtl/qfd_lock_track.sv
module qfd_lock_track
  import qfd_pkg::*;
#(
  parameter int LOCK_EDGES = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_vld,
  input  step_e step_kind,
  output logic  locked
);

  localparam int CNT_W = $clog2(LOCK_EDGES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LOCK_EDGES - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LOCK_EDGES);

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt <= '0;
      locked  <= 1'b0;
    end else if (step_vld) begin
      if (step_kind == STEP_HOLD) begin
        if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
        if (run_cnt == LAST) locked <= 1'b1;
      end else begin
        run_cnt <= '0;
        locked  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/qfd_freq_detector.sv
module qfd_freq_detector
  import qfd_pkg::*;
#(
  parameter int LOCK_EDGES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic edge_evt,
  input  logic osc_i,
  input  logic osc_q,
  output logic up_o,
  output logic dn_o,
  output logic lol_n_o
);

  step_e step_kind;
  logic  step_vld;
  logic  locked;

  // Named step events for the checker
  logic ev_hold, ev_fwd, ev_bwd, ev_jump;
  assign ev_hold = step_vld && (step_kind == STEP_HOLD);
  assign ev_fwd  = step_vld && (step_kind == STEP_FWD);
  assign ev_bwd  = step_vld && (step_kind == STEP_BWD);
  assign ev_jump = step_vld && (step_kind == STEP_JUMP);

  qfd_edge_sampler u_smp (
    .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt),
    .osc_i(osc_i), .osc_q(osc_q),
    .step_vld(step_vld), .step_kind(step_kind)
  );

  qfd_pulse_gen u_pls (
    .clk(clk), .rst_n(rst_n),
    .step_vld(step_vld), .step_kind(step_kind),
    .up_o(up_o), .dn_o(dn_o)
  );

  qfd_lock_track #(.LOCK_EDGES(LOCK_EDGES)) u_lck (
    .clk(clk), .rst_n(rst_n),
    .step_vld(step_vld), .step_kind(step_kind),
    .locked(locked)
  );

  assign lol_n_o = locked;

endmodule

// File: rtl/qfd_checker.sv
module qfd_checker (
  input logic clk,
  input logic rst_n,
  input logic edge_evt,
  input logic up_o,
  input logic dn_o,
  input logic lol_n_o,
  input logic ev_hold,
  input logic ev_fwd,
  input logic ev_bwd,
  input logic ev_jump
);

  AST_UPDN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_o && dn_o)); // R7

  AST_PULSE_AFTER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_evt |=> !up_o && !dn_o); // R7

  AST_BWD_GIVES_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bwd |=> up_o && !dn_o); // R3

  AST_FWD_GIVES_DN: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fwd |=> dn_o && !up_o); // R4

  AST_JUMP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jump |=> !up_o && !dn_o); // R5

  AST_CHANGE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fwd || ev_bwd || ev_jump) |=> !lol_n_o); // R9

  AST_LOCK_RISE_ON_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ev_hold |=> $rose(lol_n_o) || $stable(lol_n_o)); // R8

  AST_LOCKED_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    lol_n_o |-> !up_o && !dn_o); // R10

  AST_LOCK_STILL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_evt |=> $stable(lol_n_o)); // R11

endmodule

bind qfd_freq_detector qfd_checker chk_i (
  .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt),
  .up_o(up_o), .dn_o(dn_o), .lol_n_o(lol_n_o),
  .ev_hold(ev_hold), .ev_fwd(ev_fwd), .ev_bwd(ev_bwd), .ev_jump(ev_jump)
);

// File: tb/qfd_freq_detector_tb_top.sv
`timescale 1ns/1ps
module qfd_freq_detector_tb_top;

  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic edge_evt = 1'b0;
  logic osc_i = 1'b0;
  logic osc_q = 1'b0;
  logic up_o, dn_o, lol_n_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int cur = 0;   // bench's record of the last sampled quadrant

  always #2.5 clk = ~clk;

  qfd_freq_detector #(.LOCK_EDGES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .edge_evt(edge_evt),
    .osc_i(osc_i), .osc_q(osc_q),
    .up_o(up_o), .dn_o(dn_o), .lol_n_o(lol_n_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_osc(input int pos);
    case (pos & 3)
      0: {osc_i, osc_q} = 2'b00;
      1: {osc_i, osc_q} = 2'b01;
      2: {osc_i, osc_q} = 2'b11;
      default: {osc_i, osc_q} = 2'b10;
    endcase
  endtask

  // One edge at quadrant pos; returns at the negedge after the capturing edge
  task automatic edge_at(input int pos);
    @(negedge clk);
    edge_evt = 1'b1;
    set_osc(pos);
    @(negedge clk);
    edge_evt = 1'b0;
    cur = pos & 3;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic t_reset;
    check("R1 up in reset", up_o, 0);
    check("R1 dn in reset", dn_o, 0);
    check("R1 lol_n in reset", lol_n_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 up after reset", up_o, 0);
    check("R1 lol_n after reset", lol_n_o, 0);
  endtask

  task automatic t_first_edge;
    edge_at(2);
    check("R6 first edge up", up_o, 0);
    check("R6 first edge dn", dn_o, 0);
  endtask

  task automatic t_backward;
    for (int k = 0; k < 5; k++) begin
      edge_at(cur + 3);
      check("R3 backward step up", up_o, 1);
      check("R7 backward step dn", dn_o, 0);
    end
    idle(1);
    check("R7 up one cycle wide", up_o, 0);
  endtask

  task automatic t_forward;
    for (int k = 0; k < 5; k++) begin
      edge_at(cur + 1);
      check("R4 forward step dn", dn_o, 1);
      check("R7 forward step up", up_o, 0);
    end
    idle(1);
    check("R7 dn one cycle wide", dn_o, 0);
  endtask

  task automatic t_jump;
    edge_at(cur + 2);
    check("R5 jump up", up_o, 0);
    check("R5 jump dn", dn_o, 0);
  endtask

  task automatic t_ignore_between;
    int keep;
    keep = cur;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      set_osc(keep + 1 + k);
      check("R2 no pulse without edge up", up_o, 0);
      check("R2 no pulse without edge dn", dn_o, 0);
    end
    edge_at(keep);
    check("R2 same quadrant up", up_o, 0);
    check("R2 same quadrant dn", dn_o, 0);
  endtask

  // Establish a fresh reference with a jump, then hold N edges with idle gaps
  task automatic t_lock;
    edge_at(cur + 2);
    check("R9 jump clears lock", lol_n_o, 0);
    for (int k = 1; k < N; k++) begin
      edge_at(cur);
      idle(2);
      check("R11 not locked yet", lol_n_o, 0);
    end
    edge_at(cur);
    check("R8 locked after N hold edges", lol_n_o, 1);
  endtask

  task automatic t_neutral;
    for (int k = 0; k < 4; k++) begin
      edge_at(cur);
      check("R10 locked up", up_o, 0);
      check("R10 locked dn", dn_o, 0);
      check("R10 stays locked", lol_n_o, 1);
    end
    idle(5);
    check("R11 lock held over idle", lol_n_o, 1);
  endtask

  task automatic t_unlock;
    edge_at(cur + 3);
    check("R9 step drops lock", lol_n_o, 0);
    check("R3 up on unlock step", up_o, 1);
    for (int k = 1; k < N; k++) edge_at(cur);
    check("R9 count restarted", lol_n_o, 0);
    edge_at(cur);
    check("R8 relock", lol_n_o, 1);
    edge_at(cur + 2);
    check("R9 jump drops lock", lol_n_o, 0);
    check("R5 jump while locked up", up_o, 0);
    check("R5 jump while locked dn", dn_o, 0);
  endtask

  initial begin
    idle(3);
    t_reset();
    t_first_edge();
    t_backward();
    t_forward();
    t_jump();
    t_ignore_between();
    t_lock();
    t_neutral();
    t_unlock();
    idle(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 20000; k++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule